// File: doc/BRIEF.md
# Write-Update Snoopy Line Coherence Controller

This block tracks the coherence state of one cache line in a multiprocessor with snooping caches. It uses update propagation, not invalidation. When this cache writes a line that other caches also hold, it puts the new word on the bus. Every peer copy is overwritten with that word, and main memory captures it in the same transaction. A line that is held by more than one cache therefore always matches memory. For this reason one shared state is enough, and peer copies are never invalidated.

Once the line has been filled, it is always in one of three states:
- `LN_EXCL`: clean, and the only copy.
- `LN_SHRD`: held by other caches as well, and matching memory.
- `LN_DIRTY`: modified, and the only copy.

A fourth encoding, `LN_EMPTY`, marks a line that has never been filled or has been evicted. The controller also keeps the line's word.

The processor side issues read, write and evict operations. The outbound bus port carries four transactions: fill, update, write-back and supply. The snoop port delivers peer reads and peer updates along with their data. The controller drives its own shared-line output and samples the wired-OR shared-line input from the peers. Every bus transaction completes in the cycle it is issued, and arbitration happens outside this block.

Top module: `wu_line_ctrl`

## Requirements
- R1: After reset the state is `LN_EMPTY` (`line_state`=0; encodings EMPTY=0, EXCL=1, SHRD=2, DIRTY=3). While it holds that state, `bus_valid` and `snp_shared_out` are low.
- R2: A processor read (`cpu_op`=1) in EMPTY issues a fill (`bus_cmd`=0). In the same cycle `cpu_rdata` returns `bus_fill_data`, and the word is stored. The next state is SHRD if `bus_shared_in` is high during the fill, and EXCL otherwise.
- R3: A processor write (`cpu_op`=2) in EMPTY issues an update (`bus_cmd`=1) carrying `cpu_wdata`, and the word is stored. The next state is SHRD if the shared line is high, and EXCL otherwise.
- R4: A write in EXCL stores the word and moves to DIRTY with no bus transaction.
- R5: A write in SHRD issues an update carrying `cpu_wdata` and stores the word. The line stays SHRD if the shared line is high during the update, and moves to EXCL otherwise.
- R6: A write in DIRTY stores the word, stays DIRTY and issues no bus transaction. A read in any filled state returns the stored word, leaves the state unchanged and issues no bus transaction.
- R7: A snooped read (`snp_cmd`=0) in DIRTY issues a supply (`bus_cmd`=3) carrying the stored word, raises `snp_shared_out` and moves to SHRD.
- R8: A snooped read in EXCL or SHRD raises `snp_shared_out`, issues no bus transaction and leaves the line in SHRD.
- R9: A snooped update (`snp_cmd`=1) in any filled state overwrites the stored word with `snp_data`, raises `snp_shared_out` and leaves the line in SHRD. A snoop of either kind in EMPTY is ignored: the shared line stays low, and the state and word are unchanged.
- R10: An evict (`cpu_op`=3) in DIRTY issues a write-back (`bus_cmd`=2) carrying the stored word. An evict in EXCL or SHRD issues no bus transaction. In every case the next state is EMPTY.
- R11: While `snp_valid` is high, `cpu_ready` is low and the processor operation of that cycle has no effect on state, word or bus.
- R12: With no processor operation and no snoop, the bus stays idle and the state and word hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_op | input | 2 | 0 none, 1 read, 2 write, 3 evict |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_ready | output | 1 | Processor operation accepted this cycle |
| cpu_rdata | output | DATA_W | Read word |
| bus_valid | output | 1 | Outbound bus transaction this cycle |
| bus_cmd | output | 2 | 0 fill, 1 update, 2 write-back, 3 supply |
| bus_data | output | DATA_W | Outbound word (zero for fill or idle) |
| bus_shared_in | input | 1 | Wired-OR shared line from peers |
| bus_fill_data | input | DATA_W | Word returned for a fill |
| snp_valid | input | 1 | Snooped transaction for this line |
| snp_cmd | input | 1 | 0 read, 1 update |
| snp_data | input | DATA_W | Word of a snooped update |
| snp_shared_out | output | 1 | This cache holds the line (drives shared line) |
| line_state | output | 2 | Current coherence state |

## Verification
The bench aims at the shared-line sample during an update. A controller that ignored it would keep a line SHRD after the last peer dropped out, and would then broadcast on every later write instead of going to DIRTY silently. Snooped reads of a DIRTY line must both supply the data and fall to SHRD. A controller that stayed DIRTY would later write back a word memory already has, and one that failed to supply would let a peer read stale memory. Snoops that collide with a processor write or evict are driven on purpose, because a controller that let the processor through would corrupt the word or drop the line under the peer's transaction. Snoops to an EMPTY line are also driven: they must not raise the shared line, or peers would fill into SHRD needlessly.

// File: rtl/wu_pkg.sv
package wu_pkg;
    typedef enum logic [1:0] {
        LN_EMPTY = 2'd0,
        LN_EXCL  = 2'd1,
        LN_SHRD  = 2'd2,
        LN_DIRTY = 2'd3
    } ln_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_EVICT = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        BC_FILL   = 2'd0,
        BC_UPDATE = 2'd1,
        BC_WBACK  = 2'd2,
        BC_SUPPLY = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        DS_HOLD  = 2'd0,
        DS_FILL  = 2'd1,
        DS_CPU   = 2'd2,
        DS_SNOOP = 2'd3
    } data_sel_e;

    localparam logic SNP_READ   = 1'b0;
    localparam logic SNP_UPDATE = 1'b1;
endpackage

// File: rtl/wu_transition.sv
module wu_transition
    import wu_pkg::*;
(
    input  ln_state_e state,
    input  cpu_op_e   op,
    input  logic      snp_valid,
    input  logic      snp_cmd,
    input  logic      shared_in,
    output ln_state_e next_state,
    output data_sel_e data_sel
);
    always_comb begin
        next_state = state;
        data_sel   = DS_HOLD;
        if (snp_valid) begin
            // snoop has priority; processor op is stalled
            if (state != LN_EMPTY) begin
                next_state = LN_SHRD;
                if (snp_cmd == SNP_UPDATE) data_sel = DS_SNOOP;
            end
        end else begin
            unique case (state)
                LN_EMPTY: begin
                    if (op == OP_READ) begin
                        next_state = shared_in ? LN_SHRD : LN_EXCL;
                        data_sel   = DS_FILL;
                    end else if (op == OP_WRITE) begin
                        next_state = shared_in ? LN_SHRD : LN_EXCL;
                        data_sel   = DS_CPU;
                    end
                end
                LN_EXCL: begin
                    if (op == OP_WRITE) begin
                        next_state = LN_DIRTY;
                        data_sel   = DS_CPU;
                    end else if (op == OP_EVICT) begin
                        next_state = LN_EMPTY;
                    end
                end
                LN_SHRD: begin
                    if (op == OP_WRITE) begin
                        next_state = shared_in ? LN_SHRD : LN_EXCL;
                        data_sel   = DS_CPU;
                    end else if (op == OP_EVICT) begin
                        next_state = LN_EMPTY;
                    end
                end
                LN_DIRTY: begin
                    if (op == OP_WRITE) begin
                        data_sel = DS_CPU;
                    end else if (op == OP_EVICT) begin
                        next_state = LN_EMPTY;
                    end
                end
                default: next_state = LN_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/wu_emitter.sv
module wu_emitter
    import wu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  ln_state_e          state,
    input  cpu_op_e            op,
    input  logic               snp_valid,
    input  logic               snp_cmd,
    input  logic [DATA_W-1:0]  line_q,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic [DATA_W-1:0]  fill_data,
    output logic               bus_valid,
    output bus_cmd_e           bus_cmd,
    output logic [DATA_W-1:0]  bus_data,
    output logic               shared_out,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata
);
    always_comb begin
        bus_valid  = 1'b0;
        bus_cmd    = BC_FILL;
        bus_data   = '0;
        shared_out = 1'b0;
        cpu_ready  = !snp_valid;
        cpu_rdata  = (state == LN_EMPTY && op == OP_READ) ? fill_data : line_q;
        if (snp_valid) begin
            unique case (state)
                LN_EMPTY: ;
                LN_EXCL, LN_SHRD: shared_out = 1'b1;
                LN_DIRTY: begin
                    shared_out = 1'b1;
                    if (snp_cmd == SNP_READ) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_SUPPLY;
                        bus_data  = line_q;
                    end
                end
                default: ;
            endcase
        end else begin
            unique case (state)
                LN_EMPTY: begin
                    if (op == OP_READ) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_FILL;
                    end else if (op == OP_WRITE) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_UPDATE;
                        bus_data  = cpu_wdata;
                    end
                end
                LN_SHRD: begin
                    if (op == OP_WRITE) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_UPDATE;
                        bus_data  = cpu_wdata;
                    end
                end
                LN_DIRTY: begin
                    if (op == OP_EVICT) begin
                        bus_valid = 1'b1;
                        bus_cmd   = BC_WBACK;
                        bus_data  = line_q;
                    end
                end
                LN_EXCL: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wu_line_ctrl.sv
module wu_line_ctrl
    import wu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cpu_op,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  logic              snp_cmd,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_shared_out,
    output logic [1:0]        line_state
);
    ln_state_e         state_q, state_d;
    data_sel_e         dsel;
    bus_cmd_e          cmd_e;
    logic [DATA_W-1:0] word_q;
    cpu_op_e           op_e;

    assign op_e = cpu_op_e'(cpu_op);

    wu_transition u_trans (
        .state      (state_q),
        .op         (op_e),
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .shared_in  (bus_shared_in),
        .next_state (state_d),
        .data_sel   (dsel)
    );

    wu_emitter #(.DATA_W(DATA_W)) u_emit (
        .state      (state_q),
        .op         (op_e),
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .line_q     (word_q),
        .cpu_wdata  (cpu_wdata),
        .fill_data  (bus_fill_data),
        .bus_valid  (bus_valid),
        .bus_cmd    (cmd_e),
        .bus_data   (bus_data),
        .shared_out (snp_shared_out),
        .cpu_ready  (cpu_ready),
        .cpu_rdata  (cpu_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            unique case (dsel)
                DS_HOLD:  word_q <= word_q;
                DS_FILL:  word_q <= bus_fill_data;
                DS_CPU:   word_q <= cpu_wdata;
                DS_SNOOP: word_q <= snp_data;
                default:  word_q <= word_q;
            endcase
        end
    end

    assign bus_cmd    = cmd_e;
    assign line_state = state_q;
endmodule

// File: rtl/wu_line_ctrl_chk.sv
module wu_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cpu_op,
    input logic       cpu_ready,
    input logic       bus_valid,
    input logic [1:0] bus_cmd,
    input logic       snp_valid,
    input logic       snp_cmd,
    input logic       snp_shared_out,
    input logic [1:0] line_state
);
    // R4
    excl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd1 && cpu_op == 2'd2 && !snp_valid) |=> line_state == 2'd3);

    // R6
    dirty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd3 && cpu_op == 2'd2 && !snp_valid) |-> !bus_valid);

    // R7
    dirty_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd3 && snp_valid && snp_cmd == 1'b0)
            |-> (bus_valid && bus_cmd == 2'd3 && snp_shared_out));

    // R8
    snoop_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state != 2'd0 && snp_valid) |=> line_state == 2'd2);

    // R9
    empty_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd0 && snp_valid) |-> !snp_shared_out);

    // R10
    evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op == 2'd3 && cpu_ready) |=> line_state == 2'd0);

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && line_state == 2'd1 && cpu_op == 2'd2) |=> line_state != 2'd3);
endmodule

bind wu_line_ctrl wu_line_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_op         (cpu_op),
    .cpu_ready      (cpu_ready),
    .bus_valid      (bus_valid),
    .bus_cmd        (bus_cmd),
    .snp_valid      (snp_valid),
    .snp_cmd        (snp_cmd),
    .snp_shared_out (snp_shared_out),
    .line_state     (line_state)
);

// File: tb/sim_wu_line_ctrl.sv
module sim_wu_line_ctrl;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          bus_valid;
    logic [1:0]    bus_cmd;
    logic [DW-1:0] bus_data;
    logic          bus_shared_in = 1'b0;
    logic [DW-1:0] bus_fill_data = '0;
    logic          snp_valid = 1'b0;
    logic          snp_cmd = 1'b0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_shared_out;
    logic [1:0]    line_state;

    int checks = 0;
    int errors = 0;
    logic [1:0]    m_st = 2'd0;
    logic [DW-1:0] m_word = '0;

    always #5 clk = ~clk;

    wu_line_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_valid(bus_valid),
        .bus_cmd(bus_cmd), .bus_data(bus_data), .bus_shared_in(bus_shared_in),
        .bus_fill_data(bus_fill_data), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_data(snp_data), .snp_shared_out(snp_shared_out), .line_state(line_state)
    );

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic [1:0] st, logic [1:0] op, logic sv, logic sc);
        if (sv) begin
            if (op != 2'd0 && st != 2'd0) return "R11";
            if (st == 2'd0) return "R9";
            if (st == 2'd3 && !sc) return "R7";
            return sc ? "R9" : "R8";
        end
        if (op == 2'd0) return "R12";
        if (op == 2'd3) return "R10";
        if (st == 2'd0) return (op == 2'd1) ? "R2" : "R3";
        if (op == 2'd1) return "R6";
        if (st == 2'd1) return "R4";
        if (st == 2'd2) return "R5";
        return "R6";
    endfunction

    // apply one cycle of stimulus, check outputs, advance model and check state
    task automatic step(logic [1:0] op, logic [DW-1:0] wd, logic sh, logic [DW-1:0] fd,
                        logic sv, logic sc, logic [DW-1:0] sd);
        logic          e_bv;
        logic [1:0]    e_cmd;
        logic [DW-1:0] e_bd;
        logic          e_sh;
        logic [DW-1:0] e_rd;
        logic [1:0]    n_st;
        logic [DW-1:0] n_word;
        string         tg;
        @(negedge clk);
        cpu_op = op; cpu_wdata = wd; bus_shared_in = sh; bus_fill_data = fd;
        snp_valid = sv; snp_cmd = sc; snp_data = sd;
        tg = tag_of(m_st, op, sv, sc);
        e_bv = 1'b0; e_cmd = 2'd0; e_bd = '0; e_sh = 1'b0;
        e_rd = (m_st == 2'd0 && op == 2'd1) ? fd : m_word;
        n_st = m_st; n_word = m_word;
        if (sv) begin
            if (m_st != 2'd0) begin
                e_sh = 1'b1; n_st = 2'd2;
                if (sc) n_word = sd;
                else if (m_st == 2'd3) begin e_bv = 1'b1; e_cmd = 2'd3; e_bd = m_word; end
            end
        end else begin
            case (op)
                2'd1: if (m_st == 2'd0) begin
                          e_bv = 1'b1; e_cmd = 2'd0; n_st = sh ? 2'd2 : 2'd1; n_word = fd;
                      end
                2'd2: begin
                          n_word = wd;
                          if (m_st == 2'd0 || m_st == 2'd2) begin
                              e_bv = 1'b1; e_cmd = 2'd1; e_bd = wd; n_st = sh ? 2'd2 : 2'd1;
                          end else n_st = 2'd3;
                      end
                2'd3: begin
                          if (m_st == 2'd3) begin e_bv = 1'b1; e_cmd = 2'd2; e_bd = m_word; end
                          n_st = 2'd0;
                      end
                default: ;
            endcase
        end
        #2;
        check(tg, "bus_valid", DW'(bus_valid), DW'(e_bv));
        if (e_bv) begin
            check(tg, "bus_cmd", DW'(bus_cmd), DW'(e_cmd));
            check(tg, "bus_data", bus_data, e_bd);
        end
        check(tg, "shared_out", DW'(snp_shared_out), DW'(e_sh));
        check(sv ? "R11" : tg, "cpu_ready", DW'(cpu_ready), DW'(!sv));
        if (op == 2'd1 && !sv) check(tg, "cpu_rdata", cpu_rdata, e_rd);
        @(posedge clk);
        #1;
        m_st = n_st; m_word = n_word;
        check(tg, "line_state", DW'(line_state), DW'(m_st));
        if (m_st != 2'd0) check(tg, "stored word", cpu_rdata, m_word);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 20240611;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "line_state", DW'(line_state), 0);
        check("R1", "bus_valid", DW'(bus_valid), 0);
        check("R1", "shared_out", DW'(snp_shared_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // directed corner cases
        step(2'd0, 0, 1, 0, 1, 0, 0);                 // R9 snoop in EMPTY ignored
        step(2'd1, 0, 0, 32'hA5A5_0001, 0, 0, 0);     // R2 fill exclusive
        step(2'd2, 32'h1111, 1, 0, 0, 0, 0);          // R4 silent to DIRTY
        step(2'd2, 32'h2222, 1, 0, 0, 0, 0);          // R6 dirty write
        step(2'd1, 0, 0, 0, 0, 0, 0);                 // R6 read hit
        step(2'd2, 32'h3333, 0, 0, 1, 0, 0);          // R11 + R7 collision
        step(2'd2, 32'h4444, 1, 0, 0, 0, 0);          // R5 stays shared
        step(2'd2, 32'h5555, 0, 0, 0, 0, 0);          // R5 drops to exclusive
        step(2'd0, 0, 0, 0, 1, 1, 32'h6666);          // R9 update in EXCL
        step(2'd3, 0, 0, 0, 1, 0, 0);                 // R11 evict blocked, R8
        step(2'd3, 0, 0, 0, 0, 0, 0);                 // R10 evict shared
        step(2'd2, 32'h7777, 1, 0, 0, 0, 0);          // R3 write in EMPTY shared
        step(2'd3, 0, 0, 0, 0, 0, 0);                 // R10
        step(2'd2, 32'h8888, 0, 0, 0, 0, 0);          // R3 exclusive
        step(2'd2, 32'h9999, 0, 0, 0, 0, 0);          // R4
        step(2'd0, 0, 0, 0, 0, 0, 0);                 // R12 idle
        step(2'd3, 0, 0, 0, 0, 0, 0);                 // R10 write-back
        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic sv;
            sv = ($urandom % 4) == 0;
            step(2'($urandom % 4), $urandom, 1'($urandom % 2), $urandom,
                 sv, 1'($urandom % 2), $urandom);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule